// File: doc/BRIEF.md
# DRAM Command Decoder and Bank State Tracker

This block sits beside a synchronous DRAM command bus and interprets what the controller drives on it. On every rising clock edge with clock-enable high it turns the chip-select, row-strobe, column-strobe and write-enable pins into one decoded command. It uses the bank-address and address pins to qualify that command. From the accepted commands it keeps a per-bank record of which rows are open, and it runs the automatic close that a read or write may request.

The block also guards the command stream. It flags reads and writes to closed banks, activates to banks that are already open, refreshes issued with a row open, and register loads issued with a row open or too soon after the previous load. Each flagged command is rejected and leaves the tracked state untouched. A one-cycle violation pulse carries a reason code. When clock-enable is low, no command is decoded, and the block reports which power-down kind that implies. It also flags a clock-enable drop that cuts into a read or write burst. The last accepted contents of the two mode registers are visible on outputs.

Top module: `dram_cmd_tracker`

## Requirements
- R1: With clock-enable high and chip select high, the command is decoded as deselect (code 1) whatever the other pins are. It changes no bank state and raises no violation.
- R2: Pin patterns, listed as row, column, write-enable with chip select low, decode to the following codes: H,H,H no-op (2); L,H,H activate (3); H,L,H read (4, or 5 when address bit 8 is high); H,L,L write (6, or 7 when address bit 8 is high); L,H,L precharge (8, or 9 when address bit 8 is high); L,L,H refresh (10); L,L,L register load (11 when bank bit 0 is low, 12 when it is high); H,H,L reserved (13). Code 0 means nothing was decoded. Outputs are registered and appear after the sampling edge.
- R3: An activate to an idle bank sets that bank's bit in `bank_open_o`, where bit n is bank n. A precharge with address bit 8 low clears only the bank selected by the bank pins.
- R4: A precharge with address bit 8 high clears every bank bit.
- R5: A read or write with address bit 8 high keeps the bank open after the issuing edge. The bank is closed after the AP_DELAY-th following edge (default 2).
- R6: An accepted register load with bank bit 0 low copies the address pins into `mode_reg_o`. With bank bit 0 high it copies them into `ext_mode_reg_o`. Neither register changes otherwise, and both reset to 0.
- R7: A register load issued while any bank is open is rejected with reason 4 and leaves both registers unchanged.
- R8: After an accepted register load, any command other than deselect or no-op on the next MRD_GAP-1 edges (default 3) is rejected with reason 5. A command on edge MRD_GAP after the load is accepted.
- R9: A read or write to an idle bank is rejected with reason 1. An activate to an open bank is rejected with reason 2. Bank state is unchanged in both cases.
- R10: A refresh while any bank is open raises reason 3.
- R11: While clock-enable is low, pins are ignored: the command output is 0 and bank state is held. `pd_state_o` reads 1 when all banks were idle and 2 when a row was open. It reads 0 when clock-enable is high.
- R12: Clock-enable low on one of the BURST_CYCLES edges (default 2) after an accepted read or write raises reason 6. On later edges it is not flagged.
- R13: After reset, all banks are idle, the command output is 0, no violation is flagged, the power-down state is 0, and both mode registers are 0.
- R14: `viol_o` is high for exactly the cycle whose reason code is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, commands sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock-enable pin |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| addr_i | input | 12 | Address pins; bit 8 is the auto-close or all-bank flag |
| cmd_o | output | 4 | Decoded command code (R2) |
| bank_open_o | output | 4 | One bit per bank, 1 = row open |
| pd_state_o | output | 2 | 0 running, 1 idle power-down, 2 active power-down |
| viol_o | output | 1 | Protocol violation pulse |
| viol_reason_o | output | 3 | Violation reason code |
| mode_reg_o | output | 12 | Last accepted primary register load |
| ext_mode_reg_o | output | 12 | Last accepted extended register load |

## Verification
The hardest state to reach from the ports is the boundary of the post-load gap, because it needs a load that is legal in the first place. All banks must first be emptied by a precharge-all. The load is then followed by a mix of rejected commands, no-ops and deselects, one per edge, so that the edge on which a command first becomes acceptable is hit exactly. The same vector walk drives an auto-closing read through its countdown. Directed steps then drop clock-enable one, two and three edges after a write to find the edge of the burst window.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [3:0] {
    CMD_NONE  = 4'd0,
    CMD_DESEL = 4'd1,
    CMD_NOP   = 4'd2,
    CMD_ACT   = 4'd3,
    CMD_RD    = 4'd4,
    CMD_RDA   = 4'd5,
    CMD_WR    = 4'd6,
    CMD_WRA   = 4'd7,
    CMD_PRE   = 4'd8,
    CMD_PREA  = 4'd9,
    CMD_REF   = 4'd10,
    CMD_MRS   = 4'd11,
    CMD_EMRS  = 4'd12,
    CMD_RSVD  = 4'd13
  } cmd_e;

  typedef enum logic [2:0] {
    RSN_NONE      = 3'd0,
    RSN_RW_IDLE   = 3'd1,
    RSN_ACT_OPEN  = 3'd2,
    RSN_REF_OPEN  = 3'd3,
    RSN_LOAD_OPEN = 3'd4,
    RSN_LOAD_GAP  = 3'd5,
    RSN_CKE_BURST = 3'd6
  } reason_e;

  // Strobes from the control to the bank datapath; bank choice travels one-hot beside it.
  typedef struct packed {
    logic openEn;
    logic closeOne;
    logic closeAll;
    logic apArm;
    logic burstArm;
    logic loadMode;
    logic loadExt;
  } strobe_t;

endpackage

// File: rtl/dct_ctrl.sv
module dct_ctrl
  import dct_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BA_W-1:0]      ba,
  input  logic                 apFlag,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 gapBusy,
  input  logic                 burstBusy,
  output strobe_t              strb,
  output logic [NUM_BANKS-1:0] bankHot,
  output cmd_e                 cmdQ,
  output logic                 violQ,
  output reason_e              reasonQ
);

  cmd_e    decCmd;
  reason_e reason;
  logic    tgtOpen;
  logic    anyOpen;

  always_comb begin
    if (!cke)      decCmd = CMD_NONE;
    else if (csN)  decCmd = CMD_DESEL;
    else begin
      unique case ({rasN, casN, weN})
        3'b111:  decCmd = CMD_NOP;
        3'b011:  decCmd = CMD_ACT;
        3'b101:  decCmd = apFlag ? CMD_RDA : CMD_RD;
        3'b100:  decCmd = apFlag ? CMD_WRA : CMD_WR;
        3'b010:  decCmd = apFlag ? CMD_PREA : CMD_PRE;
        3'b001:  decCmd = CMD_REF;
        3'b000:  decCmd = ba[0] ? CMD_EMRS : CMD_MRS;
        default: decCmd = CMD_RSVD;
      endcase
    end
  end

  always_comb begin
    bankHot     = '0;
    bankHot[ba] = 1'b1;
  end

  assign tgtOpen = |(bankOpen & bankHot);
  assign anyOpen = |bankOpen;

  always_comb begin
    reason = RSN_NONE;
    strb   = '0;
    if (!cke) begin
      if (burstBusy) reason = RSN_CKE_BURST;
    end else if (gapBusy && decCmd != CMD_DESEL && decCmd != CMD_NOP) begin
      reason = RSN_LOAD_GAP;
    end else begin
      unique case (decCmd)
        CMD_ACT: begin
          if (tgtOpen) reason = RSN_ACT_OPEN;
          else         strb.openEn = 1'b1;
        end
        CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
          if (!tgtOpen) reason = RSN_RW_IDLE;
          else begin
            strb.burstArm = 1'b1;
            strb.apArm    = (decCmd == CMD_RDA) || (decCmd == CMD_WRA);
          end
        end
        CMD_PRE:  strb.closeOne = 1'b1;
        CMD_PREA: strb.closeAll = 1'b1;
        CMD_REF:  if (anyOpen) reason = RSN_REF_OPEN;
        CMD_MRS, CMD_EMRS: begin
          if (anyOpen) reason = RSN_LOAD_OPEN;
          else if (decCmd == CMD_MRS) strb.loadMode = 1'b1;
          else                        strb.loadExt  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdQ    <= CMD_NONE;
      reasonQ <= RSN_NONE;
      violQ   <= 1'b0;
    end else begin
      cmdQ    <= decCmd;
      reasonQ <= reason;
      violQ   <= (reason != RSN_NONE);
    end
  end

  // R1: a deselected cycle decodes as deselect and is never flagged
  assert_cs_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && csN) |=> (cmdQ == CMD_DESEL && !violQ));

  // R10: refresh with a row open is flagged unless the load gap claims it first
  assert_ref_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !csN && !rasN && !casN && weN && (|bankOpen) && !gapBusy)
      |=> (violQ && reasonQ == RSN_REF_OPEN));

  // R14: the pulse and the reason code agree
  assert_viol_reason_R14: assert property (@(posedge clk) disable iff (!rst_n)
    violQ |-> (reasonQ != RSN_NONE));

endmodule

// File: rtl/dct_bank_dp.sv
module dct_bank_dp
  import dct_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int ADDR_W       = 12,
  parameter int AP_DELAY     = 2,
  parameter int BURST_CYCLES = 2,
  parameter int MRD_GAP      = 4,
  localparam int APW = $clog2(AP_DELAY + 1),
  localparam int BCW = $clog2(BURST_CYCLES + 1),
  localparam int GCW = $clog2(MRD_GAP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  strobe_t              strb,
  input  logic [NUM_BANKS-1:0] bankHot,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic                 gapBusy,
  output logic                 burstBusy,
  output logic [1:0]           pdState,
  output logic [ADDR_W-1:0]    modeReg,
  output logic [ADDR_W-1:0]    extReg
);

  logic [GCW-1:0] gapCnt;
  logic [BCW-1:0] burstCnt;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [APW-1:0] apCnt;
    logic           hit;
    assign hit = bankHot[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bankOpen[g] <= 1'b0;
        apCnt       <= '0;
      end else if (strb.closeAll || (strb.closeOne && hit)) begin
        bankOpen[g] <= 1'b0;
        apCnt       <= '0;
      end else if (strb.openEn && hit) begin
        bankOpen[g] <= 1'b1;
      end else if (strb.apArm && hit) begin
        apCnt <= APW'(AP_DELAY);
      end else if (apCnt != '0) begin
        apCnt <= apCnt - 1'b1;
        if (apCnt == APW'(1)) bankOpen[g] <= 1'b0;
      end
    end

    // R5: the last countdown step closes the bank unless it is re-armed
    assert_ap_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (apCnt == APW'(1) && !(strb.apArm && hit)) |=> !bankOpen[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gapCnt   <= '0;
      burstCnt <= '0;
      pdState  <= 2'd0;
      modeReg  <= '0;
      extReg   <= '0;
    end else begin
      if (strb.loadMode || strb.loadExt) gapCnt <= GCW'(MRD_GAP - 1);
      else if (gapCnt != '0)             gapCnt <= gapCnt - 1'b1;

      if (strb.burstArm)       burstCnt <= BCW'(BURST_CYCLES);
      else if (burstCnt != '0) burstCnt <= burstCnt - 1'b1;

      if (cke)            pdState <= 2'd0;
      else if (|bankOpen) pdState <= 2'd2;
      else                pdState <= 2'd1;

      if (strb.loadMode) modeReg <= addr;
      if (strb.loadExt)  extReg  <= addr;
    end
  end

  assign gapBusy   = (gapCnt != '0);
  assign burstBusy = (burstCnt != '0);

  // R4: precharge-all leaves no bank open
  assert_prea_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.closeAll |=> (bankOpen == '0));

  // R8: an accepted load opens the guard window
  assert_gap_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadMode || strb.loadExt) |=> gapBusy);

  // R6: the primary register only moves on its own load strobe
  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadMode |=> $stable(modeReg));

  // R6: the extended register only moves on its own load strobe
  assert_ext_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.loadExt |=> $stable(extReg));

endmodule

// File: rtl/dram_cmd_tracker.sv
module dram_cmd_tracker
  import dct_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int ADDR_W       = 12,
  parameter int AP_BIT       = 8,
  parameter int AP_DELAY     = 2,
  parameter int BURST_CYCLES = 2,
  parameter int MRD_GAP      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cke_i,
  input  logic                         cs_n_i,
  input  logic                         ras_n_i,
  input  logic                         cas_n_i,
  input  logic                         we_n_i,
  input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [3:0]                   cmd_o,
  output logic [NUM_BANKS-1:0]         bank_open_o,
  output logic [1:0]                   pd_state_o,
  output logic                         viol_o,
  output logic [2:0]                   viol_reason_o,
  output logic [ADDR_W-1:0]            mode_reg_o,
  output logic [ADDR_W-1:0]            ext_mode_reg_o
);

  strobe_t              strb;
  logic [NUM_BANKS-1:0] bankHot;
  logic [NUM_BANKS-1:0] bankOpen;
  logic                 gapBusy;
  logic                 burstBusy;
  cmd_e                 cmdQ;
  reason_e              reasonQ;

  dct_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cke(cke_i), .csN(cs_n_i), .rasN(ras_n_i),
    .casN(cas_n_i), .weN(we_n_i), .ba(ba_i), .apFlag(addr_i[AP_BIT]),
    .bankOpen(bankOpen), .gapBusy(gapBusy), .burstBusy(burstBusy),
    .strb(strb), .bankHot(bankHot), .cmdQ(cmdQ), .violQ(viol_o), .reasonQ(reasonQ)
  );

  dct_bank_dp #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .AP_DELAY(AP_DELAY),
    .BURST_CYCLES(BURST_CYCLES), .MRD_GAP(MRD_GAP)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cke(cke_i), .strb(strb), .bankHot(bankHot),
    .addr(addr_i), .bankOpen(bankOpen), .gapBusy(gapBusy), .burstBusy(burstBusy),
    .pdState(pd_state_o), .modeReg(mode_reg_o), .extReg(ext_mode_reg_o)
  );

  assign cmd_o         = cmdQ;
  assign viol_reason_o = reasonQ;
  assign bank_open_o   = bankOpen;

endmodule

// File: tb/dram_cmd_tracker_test.sv
module dram_cmd_tracker_test;

  localparam int CLK_PERIOD = 10;

  // pin nibble: cs, ras, cas, we
  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_PRE = 4'b0010, P_REF = 4'b0001,
                         P_LD = 4'b0000, P_RSV = 4'b0110, P_DES = 4'b1000;

  typedef struct packed {
    logic        cke;
    logic [3:0]  pins;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [3:0]  eCmd;
    logic [3:0]  eOpen;
    logic [2:0]  eRsn;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, P_NOP, 2'd0, 12'h000, 4'd2,  4'b0000, 3'd0}, // R2 no-op
    '{1'b1, P_DES, 2'd0, 12'h000, 4'd1,  4'b0000, 3'd0}, // R1 deselect masks low strobes
    '{1'b1, P_ACT, 2'd0, 12'h000, 4'd3,  4'b0001, 3'd0}, // R3 open bank 0
    '{1'b1, P_ACT, 2'd2, 12'h000, 4'd3,  4'b0101, 3'd0}, // R3 open bank 2
    '{1'b1, P_ACT, 2'd0, 12'h000, 4'd3,  4'b0101, 3'd2}, // R9 activate open bank
    '{1'b1, P_RD,  2'd1, 12'h000, 4'd4,  4'b0101, 3'd1}, // R9 read idle bank
    '{1'b1, P_WR,  2'd2, 12'h000, 4'd6,  4'b0101, 3'd0}, // R2 write
    '{1'b1, P_REF, 2'd0, 12'h000, 4'd10, 4'b0101, 3'd3}, // R10 refresh with rows open
    '{1'b1, P_PRE, 2'd0, 12'h000, 4'd8,  4'b0100, 3'd0}, // R3 single close
    '{1'b1, P_LD,  2'd0, 12'h0FF, 4'd11, 4'b0100, 3'd4}, // R7 load with row open
    '{1'b1, P_PRE, 2'd1, 12'h100, 4'd9,  4'b0000, 3'd0}, // R4 close all
    '{1'b1, P_LD,  2'd0, 12'h062, 4'd11, 4'b0000, 3'd0}, // R6 primary load
    '{1'b1, P_ACT, 2'd1, 12'h000, 4'd3,  4'b0000, 3'd5}, // R8 inside gap
    '{1'b1, P_NOP, 2'd0, 12'h000, 4'd2,  4'b0000, 3'd0}, // R8 no-op allowed in gap
    '{1'b1, P_DES, 2'd0, 12'h000, 4'd1,  4'b0000, 3'd0}, // R8 deselect allowed in gap
    '{1'b1, P_LD,  2'd1, 12'h0A5, 4'd12, 4'b0000, 3'd0}, // R8 boundary, R6 extended load
    '{1'b1, P_NOP, 2'd0, 12'h000, 4'd2,  4'b0000, 3'd0},
    '{1'b1, P_NOP, 2'd0, 12'h000, 4'd2,  4'b0000, 3'd0},
    '{1'b1, P_NOP, 2'd0, 12'h000, 4'd2,  4'b0000, 3'd0},
    '{1'b1, P_ACT, 2'd3, 12'h000, 4'd3,  4'b1000, 3'd0}, // R8 accepted on gap edge
    '{1'b1, P_RD,  2'd3, 12'h100, 4'd5,  4'b1000, 3'd0}, // R5 read with auto close
    '{1'b1, P_NOP, 2'd0, 12'h000, 4'd2,  4'b1000, 3'd0}, // R5 still open
    '{1'b1, P_NOP, 2'd0, 12'h000, 4'd2,  4'b0000, 3'd0}, // R5 closed
    '{1'b1, P_REF, 2'd0, 12'h000, 4'd10, 4'b0000, 3'd0}, // R10 refresh all idle ok
    '{1'b1, P_RSV, 2'd0, 12'h000, 4'd13, 4'b0000, 3'd0}  // R2 reserved pattern
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, csN, rasN, casN, weN;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [3:0]  cmdO;
  logic [3:0]  openO;
  logic [1:0]  pdO;
  logic        violO;
  logic [2:0]  rsnO;
  logic [11:0] modeO, extO;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cmd_tracker uut (
    .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(csN), .ras_n_i(rasN),
    .cas_n_i(casN), .we_n_i(weN), .ba_i(ba), .addr_i(addr), .cmd_o(cmdO),
    .bank_open_o(openO), .pd_state_o(pdO), .viol_o(violO), .viol_reason_o(rsnO),
    .mode_reg_o(modeO), .ext_mode_reg_o(extO)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge sample, return at the next falling edge
  task automatic step(input logic k, input logic [3:0] p, input logic [1:0] b, input logic [11:0] a);
    cke = k; {csN, rasN, casN, weN} = p; ba = b; addr = a;
    @(negedge clk);
  endtask

  task automatic checkOut(input string req, input int eCmd, input int eOpen, input int eRsn);
    chk(req, "cmd", cmdO, eCmd);
    chk(req, "bank_open", openO, eOpen);
    chk(req, "reason", rsnO, eRsn);
    chk("R14", "viol", violO, (eRsn != 0) ? 1 : 0);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rst_n = 1'b0;
    cke = 1'b1; {csN, rasN, casN, weN} = P_NOP; ba = '0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    chk("R13", "cmd", cmdO, 0);
    chk("R13", "bank_open", openO, 0);
    chk("R13", "viol", violO, 0);
    chk("R13", "pd_state", pdO, 0);
    chk("R13", "mode_reg", modeO, 0);
    chk("R13", "ext_mode_reg", extO, 0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].cke, VECS[i].pins, VECS[i].ba, VECS[i].addr);
      checkOut($sformatf("vec%0d", i), VECS[i].eCmd, VECS[i].eOpen, VECS[i].eRsn);
    end

    // R6 both register loads landed
    chk("R6", "mode_reg", modeO, 12'h062);
    chk("R6", "ext_mode_reg", extO, 12'h0A5);

    // R7 rejected load keeps the registers
    step(1'b1, P_ACT, 2'd1, 12'h000);
    checkOut("R3", 3, 4'b0010, 0);
    step(1'b1, P_LD, 2'd0, 12'hFFF);
    checkOut("R7", 11, 4'b0010, 4);
    chk("R7", "mode_reg", modeO, 12'h062);
    step(1'b1, P_LD, 2'd1, 12'hFFF);
    chk("R7", "ext_mode_reg", extO, 12'h0A5);

    // R11 clock-enable low with a row open: pins ignored, active power-down
    step(1'b0, P_PRE, 2'd1, 12'h100);
    checkOut("R11", 0, 4'b0010, 0);
    chk("R11", "pd_state", pdO, 2);
    step(1'b1, P_NOP, 2'd0, 12'h000);
    chk("R11", "pd_state", pdO, 0);
    step(1'b1, P_PRE, 2'd1, 12'h000);
    checkOut("R3", 8, 4'b0000, 0);
    step(1'b0, P_ACT, 2'd0, 12'h000);
    checkOut("R11", 0, 4'b0000, 0);
    chk("R11", "pd_state", pdO, 1);

    // R12 clock-enable dropped inside and after a write burst
    step(1'b1, P_ACT, 2'd0, 12'h000);
    step(1'b1, P_WR, 2'd0, 12'h000);
    checkOut("R2", 6, 4'b0001, 0);
    step(1'b0, P_NOP, 2'd0, 12'h000);
    checkOut("R12", 0, 4'b0001, 6);
    step(1'b0, P_NOP, 2'd0, 12'h000);
    checkOut("R12", 0, 4'b0001, 6);
    step(1'b0, P_NOP, 2'd0, 12'h000);
    checkOut("R12", 0, 4'b0001, 0);

    // R5 write with auto close
    step(1'b1, P_WR, 2'd0, 12'h100);
    checkOut("R5", 7, 4'b0001, 0);
    step(1'b1, P_NOP, 2'd0, 12'h000);
    chk("R5", "bank_open", openO, 4'b0001);
    step(1'b1, P_NOP, 2'd0, 12'h000);
    chk("R5", "bank_open", openO, 4'b0000);

    // R13 reset mid-run clears state
    step(1'b1, P_ACT, 2'd2, 12'h000);
    rst_n = 1'b0;
    step(1'b1, P_NOP, 2'd0, 12'h000);
    rst_n = 1'b1;
    chk("R13", "bank_open", openO, 0);
    chk("R13", "mode_reg", modeO, 0);

    finishRun();
  end

endmodule